// File: doc/BRIEF.md
# Stereo PWM Sample Queue

This block sits between a host register port and the modulator of a PWM audio unit. It keeps two separate sample queues, one for the left channel and one for the right. Each queue has a slot for the sample now playing and up to three samples waiting behind it. The host pushes 12-bit samples into the left queue, the right queue, or both at once. A sample tick from the period timer moves the next waiting sample, if there is one, into the playing slot.

The host learns how full each queue is by reading a status word. When a queue is full, a new push does not stall and is not lost. Instead, the oldest waiting sample is dropped so that the newest one always reaches the queue. Period generation and pulse output are handled elsewhere.

Top module: `pwmq_top`

## Requirements
- R1: After reset, both occupancy counts are 0, both current-sample outputs are 0, and both status words read 0x4000.
- R2: A write to offset 4 queues the 12-bit write data on the left channel only.
- R3: A write to offset 6 queues the 12-bit write data on the right channel only.
- R4: A write to offset 8 queues the same 12-bit data on both channels in one cycle.
- R5: On a tick, a channel holding at least one waiting sample moves its oldest waiting sample to its current output, and its occupancy drops by one.
- R6: On a tick, a channel with no waiting sample keeps its current output unchanged.
- R7: A push to a channel that already holds 3 waiting samples drops the oldest waiting sample and appends the new one. Occupancy stays 3 and the current output does not change.
- R8: The status word has bit 15 = FULL (occupancy 3) and bit 14 = EMPTY (occupancy 0), and all other bits are 0. Offset 4 reads the left status. Offsets 6 and 8 both read the right status. Any other offset reads 0.
- R9: When a tick and a push reach the same channel in the same clock, the tick's shift is applied first and the push after it.
- R10: A write to any offset other than 4, 6 or 8 changes no queue and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one push per cycle it is high |
| bus_addr_i | input | 4 | Byte offset for the write and the status read |
| bus_wdata_i | input | 12 | Sample to push |
| bus_rdata_o | output | 16 | Status word for bus_addr_i (combinational) |
| tick_i | input | 1 | Sample tick from the period timer |
| left_o | output | 12 | Current left sample |
| right_o | output | 12 | Current right sample |

## Verification
The assertions check four things on every cycle. A tick on an empty channel leaves its output alone. A tick on a non-empty channel loads the oldest waiting sample. A lone push increments occupancy, or holds it at 3 with the output unchanged when the queue is full. FULL and EMPTY are never set together. Only the bench scenarios can show the order of samples through the queue: which sample is lost on overflow, and the result when a tick and a push land in the same clock. The same holds for the address decode of left, right and mono, and for the alias of offset 8 to the right status.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
  localparam int ADDR_W    = 4;
  localparam int RDATA_W   = 16;
  localparam int SAMPLE_W  = 12;
  localparam int Q_DEPTH   = 3;
  localparam int FULL_BIT  = 15;
  localparam int EMPTY_BIT = 14;
  localparam logic [ADDR_W-1:0] OFS_LEFT  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_RIGHT = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 4'h8;
endpackage

// File: rtl/pwmq_regif.sv
module pwmq_regif
  import pwmq_pkg::*;
(
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [1:0]         full_i,   // [0] left, [1] right
  input  logic [1:0]         empty_i,
  output logic [1:0]         push_o,
  output logic [RDATA_W-1:0] rdata_o
);
  logic sel_l, sel_r, sel_b;

  assign sel_l = (addr_i == OFS_LEFT);
  assign sel_r = (addr_i == OFS_RIGHT);
  assign sel_b = (addr_i == OFS_BOTH);

  assign push_o[0] = we_i & (sel_l | sel_b);
  assign push_o[1] = we_i & (sel_r | sel_b);

  always_comb begin
    rdata_o = '0;
    if (sel_l) begin
      rdata_o[FULL_BIT]  = full_i[0];
      rdata_o[EMPTY_BIT] = empty_i[0];
    end else if (sel_r || sel_b) begin
      rdata_o[FULL_BIT]  = full_i[1];
      rdata_o[EMPTY_BIT] = empty_i[1];
    end
  end
endmodule

// File: rtl/pwmq_chan.sv
module pwmq_chan #(
  parameter int SW    = 12,
  parameter int DEPTH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          push_i,
  input  logic [SW-1:0] din_i,
  output logic [SW-1:0] cur_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH);

  logic [SW-1:0]    q_r [DEPTH];
  logic [SW-1:0]    q_t [DEPTH];
  logic [SW-1:0]    q_n [DEPTH];
  logic [OCC_W-1:0] occ_r, occ_t, occ_n;
  logic [SW-1:0]    cur_r, cur_n;

  // tick shift first, then push on the shifted state
  always_comb begin
    cur_n = cur_r;
    occ_t = occ_r;
    for (int i = 0; i < DEPTH; i++) q_t[i] = q_r[i];
    if (tick_i && occ_r != '0) begin
      cur_n = q_r[0];
      for (int i = 0; i < DEPTH - 1; i++) q_t[i] = q_r[i+1];
      occ_t = occ_r - OCC_W'(1);
    end
    occ_n = occ_t;
    for (int i = 0; i < DEPTH; i++) q_n[i] = q_t[i];
    if (push_i) begin
      if (occ_t == OCC_MAX) begin
        for (int i = 0; i < DEPTH - 1; i++) q_n[i] = q_t[i+1];
        q_n[DEPTH-1] = din_i;
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (occ_t == OCC_W'(i)) q_n[i] = din_i;
        occ_n = occ_t + OCC_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_r <= '0;
      occ_r <= '0;
      for (int i = 0; i < DEPTH; i++) q_r[i] <= '0;
    end else begin
      cur_r <= cur_n;
      occ_r <= occ_n;
      for (int i = 0; i < DEPTH; i++) q_r[i] <= q_n[i];
    end
  end

  assign cur_o   = cur_r;
  assign full_o  = (occ_r == OCC_MAX);
  assign empty_o = (occ_r == '0);

  AST_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && occ_r == '0 |=> $stable(cur_o)); // R6
  AST_TICK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && occ_r != '0 |=> cur_o == $past(q_r[0])); // R5
  AST_PUSH_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !tick_i && occ_r != OCC_MAX |=> occ_r == $past(occ_r) + OCC_W'(1)); // R2
  AST_FULL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !tick_i && full_o |=> full_o && $stable(cur_o)); // R7
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o)); // R8
endmodule

// File: rtl/pwmq_top.sv
module pwmq_top
  import pwmq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [SAMPLE_W-1:0] bus_wdata_i,
  output logic [RDATA_W-1:0]  bus_rdata_o,
  input  logic                tick_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  localparam int NCH = 2;

  logic [NCH-1:0]      push, full, empty;
  logic [SAMPLE_W-1:0] cur [NCH];

  pwmq_regif u_regif (
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .full_i  (full),
    .empty_i (empty),
    .push_o  (push),
    .rdata_o (bus_rdata_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwmq_chan #(.SW(SAMPLE_W), .DEPTH(Q_DEPTH)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .push_i  (push[c]),
      .din_i   (bus_wdata_i),
      .cur_o   (cur[c]),
      .full_o  (full[c]),
      .empty_o (empty[c])
    );
  end

  assign left_o  = cur[0];
  assign right_o = cur[1];

  AST_MONO_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && bus_addr_i == OFS_BOTH |-> push == 2'b11); // R4
endmodule

// File: tb/sim_pwmq_top.sv
module sim_pwmq_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [3:0]  bus_addr_i = 4'h0;
  logic [11:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        tick_i = 1'b0;
  logic [11:0] left_o, right_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pwmq_top u0 (.*);

  // {req[4], we, addr[4], data[12], tick, expL[12], expR[12], occL[2], occR[2]}
  localparam int NV = 17;
  localparam logic [49:0] VEC [NV] = '{
    {4'd2,  1'b1, 4'h4, 12'h011, 1'b0, 12'h000, 12'h000, 2'd1, 2'd0}, // R2
    {4'd3,  1'b1, 4'h6, 12'h022, 1'b0, 12'h000, 12'h000, 2'd1, 2'd1}, // R3
    {4'd4,  1'b1, 4'h8, 12'h033, 1'b0, 12'h000, 12'h000, 2'd2, 2'd2}, // R4
    {4'd5,  1'b0, 4'h0, 12'h000, 1'b1, 12'h011, 12'h022, 2'd1, 2'd1}, // R5
    {4'd5,  1'b0, 4'h0, 12'h000, 1'b1, 12'h033, 12'h033, 2'd0, 2'd0}, // R5
    {4'd6,  1'b0, 4'h0, 12'h000, 1'b1, 12'h033, 12'h033, 2'd0, 2'd0}, // R6
    {4'd10, 1'b1, 4'hA, 12'h0FF, 1'b0, 12'h033, 12'h033, 2'd0, 2'd0}, // R10
    {4'd2,  1'b1, 4'h4, 12'h101, 1'b0, 12'h033, 12'h033, 2'd1, 2'd0}, // R2
    {4'd2,  1'b1, 4'h4, 12'h102, 1'b0, 12'h033, 12'h033, 2'd2, 2'd0}, // R2
    {4'd8,  1'b1, 4'h4, 12'h103, 1'b0, 12'h033, 12'h033, 2'd3, 2'd0}, // R8
    {4'd7,  1'b1, 4'h4, 12'h104, 1'b0, 12'h033, 12'h033, 2'd3, 2'd0}, // R7
    {4'd9,  1'b1, 4'h4, 12'h105, 1'b1, 12'h102, 12'h033, 2'd3, 2'd0}, // R9
    {4'd7,  1'b0, 4'h0, 12'h000, 1'b1, 12'h103, 12'h033, 2'd2, 2'd0}, // R7
    {4'd7,  1'b0, 4'h0, 12'h000, 1'b1, 12'h104, 12'h033, 2'd1, 2'd0}, // R7
    {4'd9,  1'b0, 4'h0, 12'h000, 1'b1, 12'h105, 12'h033, 2'd0, 2'd0}, // R9
    {4'd9,  1'b1, 4'h8, 12'h7FF, 1'b1, 12'h105, 12'h033, 2'd1, 2'd1}, // R9
    {4'd5,  1'b0, 4'h0, 12'h000, 1'b1, 12'h7FF, 12'h7FF, 2'd0, 2'd0}  // R5
  };

  function automatic logic [15:0] stat(input logic [1:0] occ);
    return {occ == 2'd3, occ == 2'd0, 14'h0};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // outputs and all status offsets, R8 for the read decode
  task automatic check_state(input int req, input logic [11:0] el, input logic [11:0] er,
                             input logic [1:0] ol, input logic [1:0] orr);
    string t;
    t = $sformatf("R%0d", req);
    chk({t, " left"},  {4'h0, left_o},  {4'h0, el});
    chk({t, " right"}, {4'h0, right_o}, {4'h0, er});
    bus_addr_i = 4'h4; #1 chk({t, " statL"}, bus_rdata_o, stat(ol));
    bus_addr_i = 4'h6; #1 chk({t, " statR"}, bus_rdata_o, stat(orr));
    bus_addr_i = 4'h8; #1 chk("R8 stat8", bus_rdata_o, stat(orr));
    bus_addr_i = 4'h2; #1 chk("R8 statX", bus_rdata_o, 16'h0);
  endtask

  task automatic step(input logic we, input logic [3:0] a, input logic [11:0] d, input logic tk);
    @(negedge clk_i);
    bus_we_i = we; bus_addr_i = a; bus_wdata_i = d; tick_i = tk;
    @(posedge clk_i);
    #1 bus_we_i = 1'b0; tick_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_state(1, 12'h0, 12'h0, 2'd0, 2'd0); // R1 while in reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_state(1, 12'h0, 12'h0, 2'd0, 2'd0); // R1
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][45], VEC[i][44:41], VEC[i][40:29], VEC[i][28]);
      check_state(int'(VEC[i][49:46]), VEC[i][27:16], VEC[i][15:4], VEC[i][3:2], VEC[i][1:0]);
    end
    // R7 overflow on right via mono writes, then drain to confirm dropped entry
    step(1'b1, 4'h8, 12'h201, 1'b0);
    step(1'b1, 4'h8, 12'h202, 1'b0);
    step(1'b1, 4'h8, 12'h203, 1'b0);
    step(1'b1, 4'h6, 12'h204, 1'b0);
    check_state(7, 12'h7FF, 12'h7FF, 2'd3, 2'd3);
    step(1'b0, 4'h0, 12'h0, 1'b1);
    check_state(7, 12'h201, 12'h202, 2'd2, 2'd2);
    // R1 reset mid-run clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check_state(1, 12'h0, 12'h0, 2'd0, 2'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 4'h0, 12'h0, 1'b1);
    check_state(6, 12'h0, 12'h0, 2'd0, 2'd0); // R6 tick after reset holds zero
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++;
        failures++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule